// File: doc/BRIEF.md
# One-Wire Search Triplet Engine

This block performs the bit-level step of a one-wire bus search. A host pulses `start` with a direction bit. In triplet mode the engine runs two read slots on the bus. It then chooses a bit from the two values it read, and runs a write slot carrying that bit. It reports the two reads and the chosen bit in a status byte. The same engine can also run a single combined write/read slot. That slot writes the host's bit and returns the level that was sampled on the line.

The bus is open-drain. The engine has only a drive-low output and a sampled line input, and it never drives the line high. All slot timing counts in microseconds, taken from a clock-tick prescaler of `TICK_DIV` clock cycles per microsecond. The standard-speed values are parameters: a 6 us low phase for a write-1 or read slot, a 60 us low phase for a write-0 slot, a sample point 15 us into the slot, and a 70 us slot period that includes recovery.

Top module: `ow_triplet_engine`

## Requirements
- R1: During and after reset, `status` reads 0x00 and `line_low` is 0.
- R2: A `start` pulse while idle makes status bit0 (busy) high from the next clock until the last slot ends. Busy lasts three slots in triplet mode (`op_single`=0) and one slot in single-bit mode (`op_single`=1).
- R3: Every slot lasts exactly `US_SLOT`*`TICK_DIV` clock cycles, and the slots of a triplet follow each other back to back.
- R4: A read slot or a write-1 slot holds `line_low` for `US_SHORT`*`TICK_DIV` cycles. A write-0 slot holds it for `US_LONG`*`TICK_DIV` cycles. The line is sampled `US_SAMPLE` microseconds after the slot starts.
- R5: In triplet mode the first two slots are read slots. Their sampled values end up in status bit5 (first) and bit6 (second).
- R6: The third slot writes a direction bit, which is also reported in status bit7. The bit depends on the first and second reads. If they are 0 and 0, the bit is `param_msb` (bit7 of the host's parameter byte). If they are 0 and 1, it is 0. If they are 1 and 0, it is 1. If they are 1 and 1 (no device answered), it is 1.
- R7: In single-bit mode the engine writes `param_msb` in one slot and returns the sampled level in status bit5. Bits 6 and 7 read 0.
- R8: A `start` pulse while busy is ignored. The running step keeps its mode, its direction bit, its length and its result.
- R9: Status bits 7..5 change only on the clock edge where busy falls. Bits 4..1 always read 0.
- R10: `line_low` is never asserted while busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a step |
| op_single | input | 1 | 1 = single write/read slot, 0 = search triplet |
| param_msb | input | 1 | Bit7 of the parameter byte: tie-break direction or the level to write |
| line_in | input | 1 | Sampled level of the open-drain bus |
| line_low | output | 1 | 1 = pull the bus low |
| status | output | 8 | bit7 direction, bit6 second read, bit5 first read/sample, bit0 busy |

## Verification
The bench runs every triplet combination of first-read response, second-read response and tie-break bit. The responding device pulls the line low only up to 17 us into each slot. These runs separate the four branches of the direction rule, including the case where no device answers. They also catch a sample point that is too late, and the width of the third slot's low phase shows which bit was actually written. Every single-bit combination of written level and device response shows that a written 0 reads back as 0, because the engine itself holds the line low at the sample point. A final triplet receives a conflicting `start` in mid-step, which would show up as a changed length or result.

// File: rtl/ow_trip_pkg.sv
package ow_trip_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_READ_FIRST,
        SEQ_READ_SECOND,
        SEQ_WRITE_DIR,
        SEQ_SINGLE
    } seq_state_t;

    // Status byte, MSB first: bit7 direction, bit6 second read,
    // bit5 first read (or sampled level), bits 4..1 zero, bit0 busy.
    typedef struct packed {
        logic       dir;
        logic       rd_second;
        logic       rd_first;
        logic [3:0] zero;
        logic       busy;
    } ow_status_t;

    typedef struct packed {
        logic go;       // launch a slot this cycle
        logic wr_one;   // 1: short low phase (write 1 / read), 0: long low phase
    } slot_req_t;

    // Search branch choice from the two reads and the host tie-break.
    function automatic logic pick_dir(input logic first, input logic second,
                                      input logic tie);
        logic res;
        case ({first, second})
            2'b00:   res = tie;
            2'b01:   res = 1'b0;
            default: res = 1'b1;   // 10 -> 1, 11 (no response) -> 1
        endcase
        return res;
    endfunction

endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ow_slot_unit.sv
module ow_slot_unit
    import ow_trip_pkg::*;
#(
    parameter int TICK_DIV  = 50,
    parameter int US_SHORT  = 6,
    parameter int US_LONG   = 60,
    parameter int US_SAMPLE = 15,
    parameter int US_SLOT   = 70
) (
    input  logic      clk,
    input  logic      rst,
    input  slot_req_t req,
    input  logic      line_in,
    output logic      line_low,
    output logic      smp,
    output logic      done
);
    localparam int UW = $clog2(US_SLOT + 1);

    logic          active;
    logic          wr_one;
    logic [UW-1:0] us_cnt;
    logic          tick;

    ow_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (req.go),
        .tick (tick)
    );

    assign done     = active && tick && (us_cnt == UW'(US_SLOT - 1));
    assign line_low = active && (us_cnt < (wr_one ? UW'(US_SHORT) : UW'(US_LONG)));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            wr_one <= 1'b1;
            us_cnt <= '0;
            smp    <= 1'b0;
        end else if (req.go) begin
            active <= 1'b1;
            wr_one <= req.wr_one;
            us_cnt <= '0;
        end else if (active && tick) begin
            if (us_cnt == UW'(US_SAMPLE - 1)) begin
                smp <= line_in;
            end
            if (us_cnt == UW'(US_SLOT - 1)) begin
                active <= 1'b0;
            end else begin
                us_cnt <= us_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ow_trip_seq.sv
module ow_trip_seq
    import ow_trip_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       op_single,
    input  logic       dir_in,
    input  logic       smp,
    input  logic       done,
    output slot_req_t  req,
    output ow_status_t stat
);
    seq_state_t state;
    logic       rd_first;
    logic       rd_second;
    logic       dir_q;

    always_comb begin
        req = '0;
        case (state)
            SEQ_IDLE: if (start) begin
                req.go     = 1'b1;
                req.wr_one = op_single ? dir_in : 1'b1;
            end
            SEQ_READ_FIRST: if (done) begin
                req.go     = 1'b1;
                req.wr_one = 1'b1;
            end
            SEQ_READ_SECOND: if (done) begin
                req.go     = 1'b1;
                req.wr_one = pick_dir(rd_first, smp, dir_q);
            end
            default: req = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            rd_first  <= 1'b0;
            rd_second <= 1'b0;
            dir_q     <= 1'b0;
            stat      <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    dir_q     <= dir_in;
                    stat.busy <= 1'b1;
                    state     <= op_single ? SEQ_SINGLE : SEQ_READ_FIRST;
                end
                SEQ_READ_FIRST: if (done) begin
                    rd_first <= smp;
                    state    <= SEQ_READ_SECOND;
                end
                SEQ_READ_SECOND: if (done) begin
                    rd_second <= smp;
                    dir_q     <= req.wr_one;
                    state     <= SEQ_WRITE_DIR;
                end
                SEQ_WRITE_DIR: if (done) begin
                    stat.dir       <= dir_q;
                    stat.rd_second <= rd_second;
                    stat.rd_first  <= rd_first;
                    stat.zero      <= '0;
                    stat.busy      <= 1'b0;
                    state          <= SEQ_IDLE;
                end
                SEQ_SINGLE: if (done) begin
                    stat.dir       <= 1'b0;
                    stat.rd_second <= 1'b0;
                    stat.rd_first  <= smp;
                    stat.zero      <= '0;
                    stat.busy      <= 1'b0;
                    state          <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ow_triplet_engine.sv
module ow_triplet_engine
    import ow_trip_pkg::*;
#(
    parameter int TICK_DIV  = 50,
    parameter int US_SHORT  = 6,
    parameter int US_LONG   = 60,
    parameter int US_SAMPLE = 15,
    parameter int US_SLOT   = 70
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       op_single,
    input  logic       param_msb,
    input  logic       line_in,
    output logic       line_low,
    output logic [7:0] status
);
    slot_req_t  req;
    ow_status_t stat;
    logic       smp;
    logic       done;

    ow_trip_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_single (op_single),
        .dir_in    (param_msb),
        .smp       (smp),
        .done      (done),
        .req       (req),
        .stat      (stat)
    );

    ow_slot_unit #(
        .TICK_DIV  (TICK_DIV),
        .US_SHORT  (US_SHORT),
        .US_LONG   (US_LONG),
        .US_SAMPLE (US_SAMPLE),
        .US_SLOT   (US_SLOT)
    ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .line_in  (line_in),
        .line_low (line_low),
        .smp      (smp),
        .done     (done)
    );

    assign status = stat;
endmodule

// File: rtl/ow_triplet_checker.sv
module ow_triplet_checker #(
    parameter int TICK_DIV = 50,
    parameter int US_LONG  = 60
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       op_single,
    input logic       line_low,
    input logic [7:0] status
);
    localparam int LMAX = US_LONG * TICK_DIV;

    logic op_q;
    int   low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= 1'b0;
            low_run <= 0;
        end else begin
            if (start && !status[0]) op_q <= op_single;
            low_run <= line_low ? low_run + 1 : 0;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[4:1] == 4'b0000);                                        // R9
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        line_low |-> status[0]);                                        // R10
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start && !status[0] |=> status[0]);                             // R2
    AST_FLAGS_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(status[7:5]) |-> $fell(status[0]));                    // R9
    AST_DIR_RULE: assert property (@(posedge clk) disable iff (rst)
        $fell(status[0]) && !op_q |->
            (status[5] ? status[7] : (status[6] ? !status[7] : 1'b1))); // R6
    AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(status[0]) && op_q |-> status[7:6] == 2'b00);             // R7
    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        line_low |-> low_run < LMAX);                                   // R4
endmodule

bind ow_triplet_engine ow_triplet_checker #(
    .TICK_DIV (TICK_DIV),
    .US_LONG  (US_LONG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_single (op_single),
    .line_low  (line_low),
    .status    (status)
);

// File: tb/sim_ow_triplet_engine.sv
module sim_ow_triplet_engine;
    localparam int DIV  = 4;
    localparam int SLOT = 70 * DIV;
    localparam int SHRT = 6 * DIV;
    localparam int LNG  = 60 * DIV;
    localparam int PULL = 17 * DIV;   // device holds line low up to 17 us

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       op_single = 1'b0;
    logic       param_msb = 1'b0;
    logic       line_in = 1'b1;
    logic       line_low;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    ow_triplet_engine #(.TICK_DIV(DIV)) u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_single (op_single),
        .param_msb (param_msb),
        .line_in   (line_in),
        .line_low  (line_low),
        .status    (status)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic single, input logic din,
                          input logic ra, input logic rb, input logic poke);
        int   sidx = 0;
        int   phase = 0;
        int   busy_cyc = 0;
        int   guard = 0;
        int   lowc [4] = '{0, 0, 0, 0};
        logic prev_low = 1'b0;
        logic resp;
        logic pull;
        logic exp_dir;
        logic [2:0] hi0;
        int   flag_moves = 0;
        logic [7:0] exp_stat;

        @(negedge clk);
        op_single = single;
        param_msb = din;
        start     = 1'b1;
        hi0       = status[7:5];
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", int'(status[0]), 1);
        forever begin
            if (line_low && !prev_low) begin
                sidx++;
                phase = 0;
            end else begin
                phase++;
            end
            prev_low = line_low;
            if (line_low && sidx < 4) lowc[sidx]++;
            resp = (sidx == 1) ? ra : ((sidx == 2 && !single) ? rb : 1'b1);
            pull = !resp && (sidx == 1 || sidx == 2) && phase < PULL;
            line_in = !(line_low || pull);
            if (start) begin
                start     = 1'b0;
                op_single = single;
                param_msb = din;
            end
            if (!status[0]) break;
            busy_cyc++;
            if (status[7:5] != hi0) flag_moves++;
            if (poke && busy_cyc == 100) begin
                start     = 1'b1;
                op_single = !single;
                param_msb = !din;
            end
            guard++;
            if (guard > 4 * SLOT) begin
                check("R2 busy never cleared", 0, 1);
                break;
            end
            @(negedge clk);
        end
        line_in = 1'b1;

        if (single) begin
            check("R2 R3 single busy length", busy_cyc, SLOT);
            check("R4 R7 single low width", lowc[1], din ? SHRT : LNG);
            exp_stat = {2'b00, (din ? ra : 1'b0), 5'b00000};
            check("R7 single status", int'(status), int'(exp_stat));
        end else begin
            if (ra != rb)     exp_dir = ra;
            else if (ra == 0) exp_dir = din;
            else              exp_dir = 1'b1;
            check(poke ? "R8 length despite start" : "R2 R3 triplet busy length",
                  busy_cyc, 3 * SLOT);
            check("R4 R5 read slot widths", lowc[1] + lowc[2], 2 * SHRT);
            check("R4 R6 written bit width", lowc[3], exp_dir ? SHRT : LNG);
            exp_stat = {exp_dir, rb, ra, 5'b00000};
            check(poke ? "R8 result despite start" : "R5 R6 triplet status",
                  int'(status), int'(exp_stat));
        end
        check("R9 flags stable while busy", flag_moves, 0);
        check("R10 idle line released", int'(line_low), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status in reset", int'(status), 0);
        check("R1 line in reset", int'(line_low), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 status after reset", int'(status), 0);
        check("R10 line idle after reset", int'(line_low), 0);

        for (int d = 0; d < 2; d++)
            for (int a = 0; a < 2; a++)
                for (int b = 0; b < 2; b++)
                    run_op(1'b0, d[0], a[0], b[0], 1'b0);
        for (int d = 0; d < 2; d++)
            for (int a = 0; a < 2; a++)
                run_op(1'b1, d[0], a[0], 1'b1, 1'b0);
        run_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_op(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule